// File: doc/BRIEF.md
# Banked Small Memory Generator

A parameterized shallow-memory builder that produces a read-only table, a single-port RAM or a dual-port RAM. It is made from small storage banks. A bank holds 32 words, or 16 words when the second read port is present. When the address is too wide for one bank, the block replicates the banks. It steers each write to exactly one bank by decoding the upper address bits. It picks the read word with a bank-select multiplexer driven by the same upper bits.

Writes happen on the rising clock edge while the write enable is high. Reads are combinational from the address presented. The secondary read output, present in the dual-port form, has its own address and its own multiplexer. Writes always go through the primary address. Contents come from an initial-value table and a count of valid entries. Parameters are checked during elaboration, and an illegal width, an oversized list or an entry too wide for the data width stops the build. A synchronous, active-high reset reloads the initial contents into a RAM. An optional write-through mode forwards the incoming write data straight to the primary output while the write is pending.

Top module: `banked_mem`

## Requirements
- R1: Address widths from 1 to 8 and data widths from 1 to 64 build and operate. Any address width outside 1..8, a data width above 64, an entry count above the depth, or an entry with bits set at or above the data width stops elaboration.
- R2: The memory holds 2^ADDR_W independent words. A write to one address never alters any other address.
- R3: With write-through off, a write with `wr_en` high lands on the rising edge. Before that edge, `rd1_data` shows the old word at `addr`, and it shows the new word right after the edge.
- R4: With write-through on, `rd1_data` equals `wr_data` while `wr_en` is high. The word is stored at the edge.
- R5: In the dual-port kind, `rd2_data` shows the word at `rd2_addr` combinationally, independent of `addr`. When both addresses match and no write is being forwarded, both outputs agree.
- R6: In the single-port and read-only kinds, `rd2_data` is always zero.
- R7: A bank spans 5 address bits (4 in the dual-port kind). The bits above the bank field select the bank, and a write enables at most one bank, none when `wr_en` is low.
- R8: After reset, word i holds entry i of the initial table for i below the entry count, and zero at and above it. A reset of a RAM reloads these contents.
- R9: The read-only kind (KIND = 0; kind codes are 0 read-only, 1 single-port, 2 dual-port) ignores `wr_en` and `wr_data`. `rd1_data` always returns the initial contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, reloads initial contents |
| wr_data | input | DATA_W | Word to store |
| wr_en | input | 1 | Write enable for the word at `addr` |
| addr | input | ADDR_W | Write address and primary read address |
| rd2_addr | input | ADDR_W | Secondary read address (dual-port kind) |
| rd1_data | output | DATA_W | Word at `addr` |
| rd2_data | output | DATA_W | Word at `rd2_addr`, zero unless dual-port |

## Verification
Both read results are combinational, so each read is due within the same cycle as its address. A write becomes visible one edge later, unless the write-through form forwards it at once. The bench drives inputs at the falling edge and samples one nanosecond later, before the rising edge that commits any write. It compares against a model that is updated only after that sample, so a same-cycle read must show the old word. Reset reloading is checked by sweeping every address in the first read phase after reset release.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;

    typedef enum logic [1:0] {
        MK_ROM   = 2'd0,
        MK_SPRAM = 2'd1,
        MK_DPRAM = 2'd2
    } mem_kind_e;

    localparam int MAX_AW     = 8;
    localparam int MAX_DW     = 64;
    localparam int INIT_SLOTS = 1 << MAX_AW;

    typedef logic [MAX_DW-1:0] init_word_t;
    typedef init_word_t init_tab_t [INIT_SLOTS];

    // Address bits covered by one storage bank for a given memory kind.
    function automatic int bank_aw(int aw, mem_kind_e kind);
        int lim;
        lim = (kind == MK_DPRAM) ? 4 : 5;
        return (aw < lim) ? aw : lim;
    endfunction

    // True when every used table entry fits in dw bits.
    function automatic bit init_fits(init_tab_t tab, int len, int dw);
        for (int i = 0; i < INIT_SLOTS; i++) begin
            if (i < len && dw < MAX_DW && (tab[i] >> dw) != '0)
                return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/mem_bank.sv
module mem_bank
    import banked_mem_pkg::*;
#(
    parameter int        BANK_AW  = 5,
    parameter int        DATA_W   = 8,
    parameter bit        WRITABLE = 1'b1,
    parameter bit        DUAL     = 1'b0,
    parameter int        BASE     = 0,
    parameter int        INIT_LEN = 0,
    parameter init_tab_t INIT     = '{default: '0}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [BANK_AW-1:0] a1,
    input  logic [BANK_AW-1:0] a2,
    output logic [DATA_W-1:0]  q1,
    output logic [DATA_W-1:0]  q2
);
    localparam int WORDS = 1 << BANK_AW;

    function automatic logic [DATA_W-1:0] seed_word(int idx);
        init_word_t w;
        w = (BASE + idx < INIT_LEN) ? INIT[BASE + idx] : '0;
        return w[DATA_W-1:0];
    endfunction

    if (WRITABLE) begin : g_ram
        logic [DATA_W-1:0] cells [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++)
                    cells[i] <= seed_word(i);
            end else if (we) begin
                cells[a1] <= wr_data;
            end
        end

        assign q1 = cells[a1];

        if (DUAL) begin : g_port2
            assign q2 = cells[a2];
        end else begin : g_no_port2
            logic unused_a2;
            assign unused_a2 = ^a2;
            assign q2 = '0;
        end
    end else begin : g_rom
        logic unused_rom_in;
        assign unused_rom_in = ^{clk, rst, we, wr_data, a2};

        always_comb begin
            q1 = '0;
            for (int i = 0; i < WORDS; i++) begin
                if (a1 == BANK_AW'(i))
                    q1 = seed_word(i);
            end
        end
        assign q2 = '0;
    end

endmodule

// File: rtl/bank_wr_decode.sv
module bank_wr_decode #(
    parameter int SEL_W = 1,
    parameter int NBANK = 1 << SEL_W
) (
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    output logic [NBANK-1:0] bank_we
);
    always_comb begin
        for (int b = 0; b < NBANK; b++)
            bank_we[b] = we && (sel == SEL_W'(b));
    end
endmodule

// File: rtl/bank_rd_mux.sv
module bank_rd_mux #(
    parameter int SEL_W  = 1,
    parameter int NBANK  = 1 << SEL_W,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] q [NBANK],
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] y
);
    assign y = q[sel];
endmodule

// File: rtl/banked_mem.sv
module banked_mem
    import banked_mem_pkg::*;
#(
    parameter int        ADDR_W     = 6,
    parameter int        DATA_W     = 16,
    parameter mem_kind_e KIND       = MK_DPRAM,
    parameter bit        WRITE_THRU = 1'b0,
    parameter int        INIT_LEN   = 0,
    parameter init_tab_t INIT       = '{default: '0}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] rd2_addr,
    output logic [DATA_W-1:0] rd1_data,
    output logic [DATA_W-1:0] rd2_data
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int BANK_AW  = bank_aw(ADDR_W, KIND);
    localparam int SEL_W    = ADDR_W - BANK_AW;
    localparam int NBANK    = 1 << SEL_W;
    localparam int BANK_SZ  = 1 << BANK_AW;
    localparam bit WRITABLE = (KIND != MK_ROM);
    localparam bit DUAL     = (KIND == MK_DPRAM);

    // Elaboration-time parameter checks
    if (ADDR_W < 1 || ADDR_W > MAX_AW) begin : g_bad_addr_w
        $error("banked_mem: address width must lie in 1..8");
    end
    if (DATA_W < 1 || DATA_W > MAX_DW) begin : g_bad_data_w
        $error("banked_mem: data width must lie in 1..64");
    end
    if (INIT_LEN < 0 || INIT_LEN > DEPTH) begin : g_bad_init_len
        $error("banked_mem: initial list longer than the memory");
    end
    if (!init_fits(INIT, INIT_LEN, DATA_W)) begin : g_bad_init_val
        $error("banked_mem: initial value wider than the data width");
    end

    logic [NBANK-1:0]  bank_we;
    logic [DATA_W-1:0] q1_b [NBANK];
    logic [DATA_W-1:0] q2_b [NBANK];
    logic [DATA_W-1:0] mem1;
    logic [DATA_W-1:0] mem2;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mem_bank #(
            .BANK_AW (BANK_AW),
            .DATA_W  (DATA_W),
            .WRITABLE(WRITABLE),
            .DUAL    (DUAL),
            .BASE    (b * BANK_SZ),
            .INIT_LEN(INIT_LEN),
            .INIT    (INIT)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we     (bank_we[b]),
            .wr_data(wr_data),
            .a1     (addr[BANK_AW-1:0]),
            .a2     (rd2_addr[BANK_AW-1:0]),
            .q1     (q1_b[b]),
            .q2     (q2_b[b])
        );
    end

    if (NBANK == 1) begin : g_single
        assign bank_we[0] = wr_en;
        assign mem1       = q1_b[0];
        assign mem2       = q2_b[0];
    end else begin : g_multi
        bank_wr_decode #(.SEL_W(SEL_W), .NBANK(NBANK)) u_dec (
            .we     (wr_en),
            .sel    (addr[ADDR_W-1:BANK_AW]),
            .bank_we(bank_we)
        );
        bank_rd_mux #(.SEL_W(SEL_W), .NBANK(NBANK), .DATA_W(DATA_W)) u_mux1 (
            .q  (q1_b),
            .sel(addr[ADDR_W-1:BANK_AW]),
            .y  (mem1)
        );
        bank_rd_mux #(.SEL_W(SEL_W), .NBANK(NBANK), .DATA_W(DATA_W)) u_mux2 (
            .q  (q2_b),
            .sel(rd2_addr[ADDR_W-1:BANK_AW]),
            .y  (mem2)
        );
    end

    if (WRITE_THRU && WRITABLE) begin : g_fwd
        assign rd1_data = wr_en ? wr_data : mem1;
    end else begin : g_nofwd
        assign rd1_data = mem1;
    end

    assign rd2_data = DUAL ? mem2 : '0;

endmodule

// File: rtl/banked_mem_chk.sv
module banked_mem_chk
    import banked_mem_pkg::*;
#(
    parameter int        ADDR_W     = 6,
    parameter int        DATA_W     = 16,
    parameter int        NBANK      = 1,
    parameter mem_kind_e KIND       = MK_DPRAM,
    parameter bit        WRITE_THRU = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] rd2_addr,
    input logic [DATA_W-1:0] rd1_data,
    input logic [DATA_W-1:0] rd2_data,
    input logic [NBANK-1:0]  bank_we
);
    localparam bit RAM = (KIND != MK_ROM);
    localparam bit FWD = WRITE_THRU && RAM;

    p_one_bank_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we));

    p_we_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (bank_we == '0));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (RAM && wr_en) |=>
        ((addr != $past(addr)) || (rd1_data == $past(wr_data)) || (FWD && wr_en)));

    // Covers R9 as well: a read-only memory never changes under a held address.
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((!RAM || !$past(wr_en)) && !$past(rst) && $stable(addr) && !(FWD && wr_en))
        |-> $stable(rd1_data));

    p_ports_agree_r5: assert property (@(posedge clk) disable iff (rst)
        (KIND == MK_DPRAM && rd2_addr == addr && !(FWD && wr_en))
        |-> (rd2_data == rd1_data));

    p_rd2_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (KIND != MK_DPRAM) |-> (rd2_data == '0));

endmodule

bind banked_mem banked_mem_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NBANK     (NBANK),
    .KIND      (KIND),
    .WRITE_THRU(WRITE_THRU)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .addr    (addr),
    .rd2_addr(rd2_addr),
    .rd1_data(rd1_data),
    .rd2_data(rd2_data),
    .bank_we (bank_we)
);

// File: tb/tb_banked_mem.sv
`timescale 1ns/100ps
module tb_banked_mem;
    import banked_mem_pkg::*;

    function automatic init_tab_t mk_init(int n, int dw);
        init_tab_t t;
        for (int i = 0; i < INIT_SLOTS; i++)
            t[i] = (i < n) ? (64'(i * 37 + 5) & ((64'd1 << dw) - 64'd1)) : 64'd0;
        return t;
    endfunction

    function automatic logic [63:0] seed_val(int i, int n, int dw);
        return (i < n) ? (64'(i * 37 + 5) & ((64'd1 << dw) - 64'd1)) : 64'd0;
    endfunction

    localparam int        DP_LEN  = 5;
    localparam int        ROM_LEN = 6;
    localparam init_tab_t DP_INIT  = mk_init(DP_LEN, 12);
    localparam init_tab_t ROM_INIT = mk_init(ROM_LEN, 8);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [7:0]  a   = '0;
    logic [7:0]  a2  = '0;
    logic [11:0] wd  = '0;

    logic [11:0] q1_dp, q2_dp;
    logic [7:0]  q1_aw [1:8];
    logic [7:0]  q2_aw [1:8];
    logic [7:0]  q1_rom, q2_rom, q1_wt, q2_wt;

    always #2.5 clk = ~clk;

    banked_mem #(.ADDR_W(6), .DATA_W(12), .KIND(MK_DPRAM), .WRITE_THRU(1'b0),
                 .INIT_LEN(DP_LEN), .INIT(DP_INIT)) dut (
        .clk(clk), .rst(rst), .wr_data(wd), .wr_en(we), .addr(a[5:0]),
        .rd2_addr(a2[5:0]), .rd1_data(q1_dp), .rd2_data(q2_dp));

    for (genvar k = 1; k <= 8; k++) begin : g_aw
        banked_mem #(.ADDR_W(k), .DATA_W(8), .KIND(MK_SPRAM), .WRITE_THRU(1'b0),
                     .INIT_LEN(0)) u_mem (
            .clk(clk), .rst(rst), .wr_data(wd[7:0]), .wr_en(we), .addr(a[k-1:0]),
            .rd2_addr(a2[k-1:0]), .rd1_data(q1_aw[k]), .rd2_data(q2_aw[k]));
    end

    banked_mem #(.ADDR_W(3), .DATA_W(8), .KIND(MK_ROM), .WRITE_THRU(1'b0),
                 .INIT_LEN(ROM_LEN), .INIT(ROM_INIT)) rom_u (
        .clk(clk), .rst(rst), .wr_data(wd[7:0]), .wr_en(we), .addr(a[2:0]),
        .rd2_addr(a2[2:0]), .rd1_data(q1_rom), .rd2_data(q2_rom));

    banked_mem #(.ADDR_W(5), .DATA_W(8), .KIND(MK_SPRAM), .WRITE_THRU(1'b1),
                 .INIT_LEN(0)) wt_u (
        .clk(clk), .rst(rst), .wr_data(wd[7:0]), .wr_en(we), .addr(a[4:0]),
        .rd2_addr(a2[4:0]), .rd1_data(q1_wt), .rd2_data(q2_wt));

    // Behavioural models
    logic [11:0] m_dp [64];
    logic [7:0]  m_aw [1:8][256];
    logic [7:0]  m_wt [32];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h (addr=%0h addr2=%0h we=%0b)",
                     req, act, exp, a, a2, we);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " dp rd1"}, 64'(q1_dp), 64'(m_dp[a[5:0]]));
        chk("R5 dp rd2", 64'(q2_dp), 64'(m_dp[a2[5:0]]));
        for (int k = 1; k <= 8; k++) begin
            chk((k == 1 || k == 8) ? "R1 width edge rd1" : "R2 width sweep rd1",
                64'(q1_aw[k]), 64'(m_aw[k][int'(a) % (1 << k)]));
            chk("R6 single-port rd2", 64'(q2_aw[k]), 64'd0);
        end
        chk("R9 rom rd1", 64'(q1_rom), seed_val(int'(a[2:0]), ROM_LEN, 8));
        chk("R6 rom rd2", 64'(q2_rom), 64'd0);
        chk("R4 write-through rd1", 64'(q1_wt), we ? 64'(wd[7:0]) : 64'(m_wt[a[4:0]]));
        chk("R6 write-through rd2", 64'(q2_wt), 64'd0);
    endtask

    task automatic cycle(string tag, logic w, logic [7:0] ad, logic [7:0] ad2, logic [11:0] d);
        @(negedge clk);
        we = w; a = ad; a2 = ad2; wd = d;
        #1;
        check_all(tag);
        if (w) begin
            m_dp[ad[5:0]] = d;
            for (int k = 1; k <= 8; k++)
                m_aw[k][int'(ad) % (1 << k)] = d[7:0];
            m_wt[ad[4:0]] = d[7:0];
        end
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++)
            m_dp[i] = seed_val(i, DP_LEN, 12)[11:0];
        for (int k = 1; k <= 8; k++)
            for (int i = 0; i < 256; i++)
                m_aw[k][i] = '0;
        for (int i = 0; i < 32; i++)
            m_wt[i] = '0;
    endtask

    initial begin
        do_reset();

        // R8: initial contents and zero fill, every address
        for (int i = 0; i < 256; i++)
            cycle("R8 init", 1'b0, 8'(i), 8'(255 - i), 12'd0);

        // R3: same-cycle read shows old word, next cycle the new one
        cycle("R3 collide", 1'b1, 8'd10, 8'd10, 12'habc);
        cycle("R3 after write", 1'b0, 8'd10, 8'd10, 12'd0);
        cycle("R3 after write", 1'b0, 8'd11, 8'd10, 12'd0);

        // R7: writes straddling bank boundaries, then readback
        cycle("R7 bank edge", 1'b1, 8'd15,  8'd16, 12'h111);
        cycle("R7 bank edge", 1'b1, 8'd16,  8'd15, 12'h222);
        cycle("R7 bank edge", 1'b1, 8'd31,  8'd32, 12'h333);
        cycle("R7 bank edge", 1'b1, 8'd32,  8'd31, 12'h444);
        cycle("R7 bank edge", 1'b1, 8'd63,  8'd0,  12'h555);
        cycle("R7 bank edge", 1'b1, 8'd255, 8'd63, 12'h666);
        for (int i = 0; i < 256; i++)
            cycle("R7 readback", 1'b0, 8'(i), 8'(i ^ 16), 12'd0);

        // R2/R3/R4/R5/R9: random mixed traffic
        for (int i = 0; i < 3000; i++)
            cycle("R2 random", 1'($urandom % 2), 8'($urandom), 8'($urandom), 12'($urandom));

        // R2: fill every address with a distinct pattern, then read back
        for (int i = 0; i < 256; i++)
            cycle("R2 fill", 1'b1, 8'(i), 8'(i), 12'(i * 3 + 1));
        for (int i = 0; i < 256; i++)
            cycle("R2 readback", 1'b0, 8'(i), 8'(255 - i), 12'd0);

        // R8: reset reloads the initial contents
        do_reset();
        for (int i = 0; i < 256; i++)
            cycle("R8 reload", 1'b0, 8'(i), 8'(i), 12'd0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule